// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the five interrupt causes of a 16550-style serial port into one pending-interrupt line and an 8-bit identification byte. Software reads that byte to learn which cause to service. The causes are receiver line errors, received data available, character timeout, transmit holding register empty and modem status change.

Another part of the chip produces the cause signals: the receive and transmit datapaths, the timeout counter and the modem line sampler. This block applies the per-cause enable bits, keeps the two causes that need memory, and reports the most urgent active cause. The first cause with memory is the transmit-empty arm, which is cleared when the identification byte is read. The second is the timeout indication, which is cleared when the receive buffer is read.

Both outputs are registered. They reflect the inputs and the internal state as sampled at the previous rising clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst` is high at a rising edge, `iid` becomes 0x01 and `irq` becomes 0. The transmit-empty arm and the timeout latch are also cleared.
- R2: With no active cause, `iid` is 0x01. `irq` always equals the inverse of `iid` bit 0.
- R3: A receiver line cause is active when `ien` bit 2 is 1 and any `lsr_err` bit is 1 (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break). It reports 0x06 and outranks every other cause.
- R4: A received-data cause is active only when `ien` bit 0 is 1 and `rx_ready` is 1. It reports 0x04 and ranks second.
- R5: A one-cycle `char_timeout` pulse sets a timeout latch whatever the enables are. A `rbr_rd` pulse clears it, and a clear in the same cycle as a set wins. The latch reports 0x0C when `ien` bit 0 is 1, and it ranks below received data.
- R6: The transmit-empty arm is set by a rising edge of `thr_empty`. When `ien` bit 1 is 1 it reports 0x02, ranking below the timeout. The arm drops whenever `thr_empty` is 0.
- R7: A rising edge of `ien` bit 1 while `thr_empty` is 1 sets the transmit-empty arm. The 0x02 code appears after that edge.
- R8: An `iid_rd` pulse in a cycle when `iid` shows 0x02 clears the transmit-empty arm. The arm is set again only by the next rising edge of `thr_empty` or of `ien` bit 1.
- R9: A modem cause is active when `ien` bit 3 is 1 and `msr_change` is 1. It reports 0x00 and has the lowest rank.
- R10: `iid` and `irq` change only at a rising clock edge. An input change shows on them after the next rising edge.
- R11: Only the highest active cause is reported, and lower causes stay held. An `iid_rd` pulse while `iid` shows a code other than 0x02 leaves the transmit-empty arm unchanged.
- R12: `ien` bits above bit 3 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien | input | IEN_W (8) | Interrupt enable byte: bit 0 receive data and timeout, bit 1 transmit empty, bit 2 line errors, bit 3 modem |
| lsr_err | input | ERR_W (4) | Receiver error flags: overrun, parity, framing, break |
| rx_ready | input | 1 | Received byte waiting in the buffer |
| char_timeout | input | 1 | One-cycle pulse marking a character timeout |
| thr_empty | input | 1 | Transmit holding register is empty |
| msr_change | input | 1 | A modem input line changed |
| iid_rd | input | 1 | Software reads the identification byte this cycle |
| rbr_rd | input | 1 | Software reads the receive buffer this cycle |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Interrupt pending |

## Verification
Each cause is driven alone, and then in pairs and with every cause active, so that each code and each ranking between neighbours is seen. The line-error flags are applied one bit at a time to show that every flag alone reaches code 0x06. Read sequences cover four cases: a read while 0x02 shows, a read while a higher code hides a pending transmit-empty arm, a receive buffer read against a held timeout, and a fall and rise of `thr_empty` after a clearing read. Together these separate the clear and re-arm rules from plain level decoding. Enable edges, masked enables and the unused upper enable bits show that the enables gate causes and start the transmit-empty arm only through bit 1.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W    = 8;
  localparam int NUM_SRC = 5;

  // enable bit positions
  localparam int EN_RDA  = 0;
  localparam int EN_THRE = 1;
  localparam int EN_RLS  = 2;
  localparam int EN_MS   = 3;

  // source index, 0 is the most urgent
  localparam int SRC_RLS  = 0;
  localparam int SRC_RDA  = 1;
  localparam int SRC_CTI  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MS   = 4;

  localparam logic [ID_W-1:0] ID_NONE = 8'h01;
  localparam logic [ID_W-1:0] ID_RLS  = 8'h06;
  localparam logic [ID_W-1:0] ID_RDA  = 8'h04;
  localparam logic [ID_W-1:0] ID_CTI  = 8'h0C;
  localparam logic [ID_W-1:0] ID_THRE = 8'h02;
  localparam logic [ID_W-1:0] ID_MS   = 8'h00;

  function automatic logic [ID_W-1:0] src_code(input int idx);
    case (idx)
      SRC_RLS:  return ID_RLS;
      SRC_RDA:  return ID_RDA;
      SRC_CTI:  return ID_CTI;
      SRC_THRE: return ID_THRE;
      default:  return ID_MS;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_resolve.sv
module uart_irq_resolve
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]    act,
  output logic [ID_W-1:0] id_nxt
);
  // walk from lowest to highest rank so the most urgent cause wins
  always_comb begin
    id_nxt = ID_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) id_nxt = src_code(i);
    end
  end
endmodule

// File: rtl/uart_thre_arm.sv
module uart_thre_arm (
  input  logic clk,
  input  logic rst,
  input  logic thr_empty,
  input  logic en,
  input  logic clr_req,
  output logic pend_nxt
);
  logic empty_q, en_q, pend_q, set_ev;

  assign set_ev = thr_empty & (~empty_q | (en & ~en_q));

  always_comb begin
    if (set_ev)          pend_nxt = 1'b1;
    else if (!thr_empty) pend_nxt = 1'b0;
    else if (clr_req)    pend_nxt = 1'b0;
    else                 pend_nxt = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= thr_empty;
      en_q    <= en;
      pend_q  <= pend_nxt;
    end
  end
endmodule

// File: rtl/uart_event_latch.sv
module uart_event_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_nxt
);
  logic q;

  // clear beats set in the same cycle
  assign q_nxt = clr_i ? 1'b0 : (set_i | q);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int IEN_W = 8,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IEN_W-1:0] ien,
  input  logic [ERR_W-1:0] lsr_err,
  input  logic             rx_ready,
  input  logic             char_timeout,
  input  logic             thr_empty,
  input  logic             msr_change,
  input  logic             iid_rd,
  input  logic             rbr_rd,
  output logic [ID_W-1:0]  iid,
  output logic             irq
);
  logic               thre_nxt, tmo_nxt, thre_clr;
  logic [NUM_SRC-1:0] act;
  logic [ID_W-1:0]    id_nxt;

  assign thre_clr = iid_rd && (iid == ID_THRE);

  uart_thre_arm u_thre (
    .clk      (clk),
    .rst      (rst),
    .thr_empty(thr_empty),
    .en       (ien[EN_THRE]),
    .clr_req  (thre_clr),
    .pend_nxt (thre_nxt)
  );

  uart_event_latch u_tmo (
    .clk  (clk),
    .rst  (rst),
    .set_i(char_timeout),
    .clr_i(rbr_rd),
    .q_nxt(tmo_nxt)
  );

  always_comb begin
    act           = '0;
    act[SRC_RLS]  = ien[EN_RLS] & (|lsr_err);
    act[SRC_RDA]  = ien[EN_RDA] & rx_ready;
    act[SRC_CTI]  = ien[EN_RDA] & tmo_nxt;
    act[SRC_THRE] = ien[EN_THRE] & thre_nxt;
    act[SRC_MS]   = ien[EN_MS] & msr_change;
  end

  uart_irq_resolve #(.N(NUM_SRC)) u_res (
    .act   (act),
    .id_nxt(id_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iid <= ID_NONE;
      irq <= 1'b0;
    end else begin
      iid <= id_nxt;
      irq <= ~id_nxt[0];
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int IEN_W = 8,
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [IEN_W-1:0] ien,
  input logic [ERR_W-1:0] lsr_err,
  input logic             rx_ready,
  input logic             thr_empty,
  input logic             msr_change,
  input logic             iid_rd,
  input logic [ID_W-1:0]  iid,
  input logic             irq
);
  AST_IRQ_FOLLOWS_ID: assert property (@(posedge clk) disable iff (rst) irq == ~iid[0]); // R2
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (iid == ID_NONE && !irq)); // R1
  AST_RLS_WINS: assert property (@(posedge clk) disable iff (rst)
    (ien[EN_RLS] && |lsr_err) |=> iid == ID_RLS); // R3
  AST_RDA_SECOND: assert property (@(posedge clk) disable iff (rst)
    (ien[EN_RDA] && rx_ready && !(ien[EN_RLS] && |lsr_err)) |=> iid == ID_RDA); // R4
  AST_THRE_MASKED: assert property (@(posedge clk) disable iff (rst)
    !ien[EN_THRE] |=> iid != ID_THRE); // R6
  AST_THRE_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (iid_rd && iid == ID_THRE && thr_empty && ien[EN_THRE]) |=> iid != ID_THRE); // R8
  AST_MS_RAISES: assert property (@(posedge clk) disable iff (rst)
    (ien[EN_MS] && msr_change) |=> irq); // R9
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.IEN_W(IEN_W), .ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ien       (ien),
  .lsr_err   (lsr_err),
  .rx_ready  (rx_ready),
  .thr_empty (thr_empty),
  .msr_change(msr_change),
  .iid_rd    (iid_rd),
  .iid       (iid),
  .irq       (irq)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ien = '0;
  logic [3:0] lsr_err = '0;
  logic       rx_ready = 1'b0, char_timeout = 1'b0, thr_empty = 1'b1;
  logic       msr_change = 1'b0, iid_rd = 1'b0, rbr_rd = 1'b0;
  logic [7:0] iid;
  logic       irq;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst(rst), .ien(ien), .lsr_err(lsr_err), .rx_ready(rx_ready),
    .char_timeout(char_timeout), .thr_empty(thr_empty), .msr_change(msr_change),
    .iid_rd(iid_rd), .rbr_rd(rbr_rd), .iid(iid), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_id(input string req, input logic [7:0] exp);
    total++;
    if (iid !== exp || irq !== (exp != 8'h01)) begin
      bad++;
      $display("FAIL %s: iid=%02h irq=%0b expected iid=%02h irq=%0b",
               req, iid, irq, exp, (exp != 8'h01));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check_id("R1", 8'h01);
    rst = 1'b0;
    tick();
    check_id("R2", 8'h01);
    rx_ready = 1'b1;               // R4: data with bit 0 clear
    tick();
    check_id("R4", 8'h01);
    rx_ready = 1'b0;
  endtask

  task automatic t_rls();
    ien = 8'h04;
    for (int b = 0; b < 4; b++) begin
      lsr_err = 4'b1 << b;
      tick();
      check_id("R3", 8'h06);
    end
    lsr_err = 4'hF; ien = 8'h00;
    tick();
    check_id("R3", 8'h01);
    ien = 8'hF0; rx_ready = 1'b1; msr_change = 1'b1;   // R12
    tick();
    check_id("R12", 8'h01);
    ien = 8'h0F;
    tick();
    check_id("R3", 8'h06);
    lsr_err = 4'h0;
    tick();
    check_id("R4", 8'h04);
    ien = 8'h00; rx_ready = 1'b0; msr_change = 1'b0;
    tick();
    check_id("R2", 8'h01);
  endtask

  task automatic t_thre();
    thr_empty = 1'b0;
    tick();
    thr_empty = 1'b1;              // rise while masked: arm held
    tick();
    check_id("R6", 8'h01);
    ien = 8'h02;
    #1 check_id("R10", 8'h01);
    tick();
    check_id("R7", 8'h02);
    iid_rd = 1'b1;
    tick();
    check_id("R8", 8'h01);
    iid_rd = 1'b0;
    tick();
    check_id("R8", 8'h01);
    thr_empty = 1'b0;
    tick();
    check_id("R6", 8'h01);
    thr_empty = 1'b1;
    tick();
    check_id("R8", 8'h02);
  endtask

  task automatic t_retain();
    ien = 8'h03; rx_ready = 1'b1;
    tick();
    check_id("R4", 8'h04);
    iid_rd = 1'b1;
    tick();
    check_id("R11", 8'h04);
    iid_rd = 1'b0; rx_ready = 1'b0;
    tick();
    check_id("R11", 8'h02);
    iid_rd = 1'b1;
    tick();
    iid_rd = 1'b0;
    check_id("R8", 8'h01);
    ien = 8'h00;
    tick();
  endtask

  task automatic t_cti();
    char_timeout = 1'b1;           // latched while masked
    tick();
    char_timeout = 1'b0;
    check_id("R5", 8'h01);
    ien = 8'h01;
    tick();
    check_id("R5", 8'h0C);
    rx_ready = 1'b1;
    tick();
    check_id("R5", 8'h04);
    rx_ready = 1'b0;
    tick();
    check_id("R5", 8'h0C);
    rbr_rd = 1'b1;
    tick();
    rbr_rd = 1'b0;
    check_id("R5", 8'h01);
    char_timeout = 1'b1; rbr_rd = 1'b1;   // clear wins
    tick();
    char_timeout = 1'b0; rbr_rd = 1'b0;
    check_id("R5", 8'h01);
    ien = 8'h00;
    tick();
  endtask

  task automatic t_ms();
    ien = 8'h08; msr_change = 1'b1;
    tick();
    check_id("R9", 8'h00);
    ien = 8'h0A;                   // bit 1 rises with empty holding register
    tick();
    check_id("R9", 8'h02);
    iid_rd = 1'b1;
    tick();
    iid_rd = 1'b0;
    check_id("R9", 8'h00);
    msr_change = 1'b0;
    tick();
    check_id("R2", 8'h01);
    ien = 8'h00;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_rls();
    t_thre();
    t_retain();
    t_cti();
    t_ms();
    finish_run();
  end
endmodule